// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the bit-rate tick of a 16550-style serial port from a fixed crystal clock. A phase accumulator adds a programmable multiplier on every crystal cycle and wraps at a programmable modulus. This produces a derived clock enable whose average rate is the crystal rate times the multiplier over the modulus. Two counter stages then divide that enable: a prescaler first, then a 16-bit divisor latch. Every output is a one-cycle enable pulse in the crystal clock domain, and no clock net is generated.

A small word-wide register port sets the multiplier, the modulus, the prescale value and the two divisor bytes, and reads them back. The address of each register is its index shifted left by a configurable amount, plus a base offset. Out of reset the block holds values that give 115200 baud from a 38.4 MHz crystal: multiplier 96, modulus 125, prescale 16, divisor 16. That is a 29.4912 MHz derived rate.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, reads return multiplier 96, modulus 125, prescale 16, divisor low byte 16 and divisor high byte 0. The read data appears one clock after the address is presented.
- R2: A register lives at byte address BASE_OFS + (index << REG_SHIFT). The indices are: divisor low byte 0, divisor high byte 1, prescale 12, multiplier 13, modulus 14. With the defaults these are 0x00, 0x04, 0x30, 0x34 and 0x38. Written values read back; the divisor bytes take write bits [7:0].
- R3: While the multiplier does not exceed a nonzero modulus, uclk_en pulses exactly multiplier times in every modulus crystal cycles. The accumulator always stays below the modulus.
- R4: A modulus of 0 holds uclk_en and baud_tick low.
- R5: A multiplier above the modulus acts as a multiplier equal to the modulus, so uclk_en is high on every cycle.
- R6: baud_tick fires once per prescale × divisor pulses of uclk_en. With multiplier 1, modulus 4, prescale 2 and divisor 3, ticks are 24 cycles apart.
- R7: A prescale of 0 or a divisor of 0 counts as 1. With multiplier 1, modulus 2 and both set to 0, ticks are 2 cycles apart.
- R8: A write to the prescale, multiplier or modulus register clears the accumulator and the prescale counter. With multiplier 1, modulus 4, prescale 2 and divisor 1, the first new tick comes 10 clocks after the write edge, whatever phase the write lands on.
- R9: With the reset settings, 100000 crystal cycles give 300 baud ticks, within one tick.
- R10: baud_tick is a single-cycle pulse whenever the tick period exceeds one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Write data word |
| rdata | output | DATA_W | Registered read data for addr |
| uclk_en | output | 1 | Derived clock enable pulse |
| baud_tick | output | 1 | Baud tick pulse |

## Verification
A register write that clears the ratio state can land in the same cycle as a derived enable or a prescaler pulse that is already in flight. The bench lets the generator run and then rewrites the prescale value at several different cycle offsets. Some of these offsets line up the write with an enable edge. In each case the first tick after the write must still arrive exactly 10 clocks after the write edge. Any pulse inside the first cycle, which comes from the stage downstream of the clear, is ignored.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;
  typedef enum logic [3:0] {
    IDX_DIVL = 4'd0,
    IDX_DIVH = 4'd1,
    IDX_PRE  = 4'd12,
    IDX_MUL  = 4'd13,
    IDX_MOD  = 4'd14
  } reg_idx_e;

  localparam int RST_MUL  = 96;
  localparam int RST_MOD  = 125;
  localparam int RST_PRE  = 16;
  localparam int RST_DIVR = 16;
endpackage

// File: rtl/frac_baud_regs.sv
module frac_baud_regs
  import frac_baud_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int FRAC_W    = 16,
  parameter int PRE_W     = 8,
  parameter int DIVR_W    = 16,
  parameter int REG_SHIFT = 2,
  parameter int BASE_OFS  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [FRAC_W-1:0] mul,
  output logic [FRAC_W-1:0] modv,
  output logic [PRE_W-1:0]  pre,
  output logic [DIVR_W-1:0] divr,
  output logic              clr
);
  localparam logic [ADDR_W-1:0] A_DIVL = ADDR_W'(BASE_OFS + (int'(IDX_DIVL) << REG_SHIFT));
  localparam logic [ADDR_W-1:0] A_DIVH = ADDR_W'(BASE_OFS + (int'(IDX_DIVH) << REG_SHIFT));
  localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(BASE_OFS + (int'(IDX_PRE)  << REG_SHIFT));
  localparam logic [ADDR_W-1:0] A_MUL  = ADDR_W'(BASE_OFS + (int'(IDX_MUL)  << REG_SHIFT));
  localparam logic [ADDR_W-1:0] A_MOD  = ADDR_W'(BASE_OFS + (int'(IDX_MOD)  << REG_SHIFT));
  localparam int HALF_W = DIVR_W / 2;

  logic hit_pre, hit_mul, hit_mod, hit_dl, hit_dh;
  logic [FRAC_W-1:0] frac_sat;
  logic [PRE_W-1:0]  pre_sat;

  assign hit_pre = (addr == A_PRE);
  assign hit_mul = (addr == A_MUL);
  assign hit_mod = (addr == A_MOD);
  assign hit_dl  = (addr == A_DIVL);
  assign hit_dh  = (addr == A_DIVH);

  // oversized writes saturate to the field maximum
  assign frac_sat = (|(wdata >> FRAC_W)) ? '1 : wdata[FRAC_W-1:0];
  assign pre_sat  = (|(wdata >> PRE_W))  ? '1 : wdata[PRE_W-1:0];

  assign clr = wr_en && (hit_pre || hit_mul || hit_mod);

  always_ff @(posedge clk) begin
    if (rst) begin
      mul  <= FRAC_W'(RST_MUL);
      modv <= FRAC_W'(RST_MOD);
      pre  <= PRE_W'(RST_PRE);
      divr <= DIVR_W'(RST_DIVR);
    end else if (wr_en) begin
      if (hit_mul) mul  <= frac_sat;
      if (hit_mod) modv <= frac_sat;
      if (hit_pre) pre  <= pre_sat;
      if (hit_dl)  divr[HALF_W-1:0]      <= wdata[HALF_W-1:0];
      if (hit_dh)  divr[DIVR_W-1:HALF_W] <= wdata[DIVR_W-HALF_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (hit_mul) rdata <= DATA_W'(mul);
      if (hit_mod) rdata <= DATA_W'(modv);
      if (hit_pre) rdata <= DATA_W'(pre);
      if (hit_dl)  rdata <= DATA_W'(divr[HALF_W-1:0]);
      if (hit_dh)  rdata <= DATA_W'(divr[DIVR_W-1:HALF_W]);
    end
  end
endmodule

// File: rtl/frac_phase_acc.sv
module frac_phase_acc #(
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [FRAC_W-1:0] mul,
  input  logic [FRAC_W-1:0] modv,
  output logic [FRAC_W-1:0] acc,
  output logic              en
);
  logic [FRAC_W-1:0] mul_eff;
  logic [FRAC_W:0]   sum;
  logic              wrap;

  assign mul_eff = (mul > modv) ? modv : mul;
  assign sum     = {1'b0, acc} + {1'b0, mul_eff};
  assign wrap    = (modv != '0) && (sum >= {1'b0, modv});

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc <= '0;
      en  <= 1'b0;
    end else if (modv == '0) begin
      acc <= '0;
      en  <= 1'b0;
    end else begin
      acc <= wrap ? FRAC_W'(sum - {1'b0, modv}) : sum[FRAC_W-1:0];
      en  <= wrap;
    end
  end
endmodule

// File: rtl/frac_pulse_div.sv
module frac_pulse_div #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             in_pulse,
  input  logic [CNT_W-1:0] limit,
  output logic             out_pulse
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // a limit of zero counts as one
  assign last = (limit == '0) ? '0 : limit - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt       <= '0;
      out_pulse <= 1'b0;
    end else begin
      out_pulse <= 1'b0;
      if (in_pulse) begin
        if (cnt >= last) begin
          cnt       <= '0;
          out_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int FRAC_W    = 16,
  parameter int PRE_W     = 8,
  parameter int DIVR_W    = 16,
  parameter int REG_SHIFT = 2,
  parameter int BASE_OFS  = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              uclk_en,
  output logic              baud_tick
);
  logic [FRAC_W-1:0] mul_w, mod_w, acc_w;
  logic [PRE_W-1:0]  pre_w;
  logic [DIVR_W-1:0] divr_w;
  logic              clr_w, pre_pulse_w;

  frac_baud_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W),
    .DIVR_W(DIVR_W), .REG_SHIFT(REG_SHIFT), .BASE_OFS(BASE_OFS)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .mul(mul_w), .modv(mod_w), .pre(pre_w), .divr(divr_w),
    .clr(clr_w)
  );

  frac_phase_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst(rst), .clr(clr_w), .mul(mul_w), .modv(mod_w),
    .acc(acc_w), .en(uclk_en)
  );

  frac_pulse_div #(.CNT_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clr(clr_w), .in_pulse(uclk_en),
    .limit(pre_w), .out_pulse(pre_pulse_w)
  );

  frac_pulse_div #(.CNT_W(DIVR_W)) u_divr (
    .clk(clk), .rst(rst), .clr(1'b0), .in_pulse(pre_pulse_w),
    .limit(divr_w), .out_pulse(baud_tick)
  );
endmodule

// File: rtl/frac_baud_gen_chk.sv
module frac_baud_gen_chk #(
  parameter int FRAC_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic [FRAC_W-1:0] modv,
  input logic [FRAC_W-1:0] acc,
  input logic              uclk_en,
  input logic              pre_pulse,
  input logic              baud_tick
);
  a_r3_acc_below_mod: assert property (@(posedge clk) disable iff (rst)
    (acc < modv) || (acc == '0));

  a_r4_mod_zero_idle: assert property (@(posedge clk) disable iff (rst)
    (modv == '0) |=> !uclk_en);

  a_r6_tick_follows_pre: assert property (@(posedge clk) disable iff (rst)
    baud_tick |-> $past(pre_pulse));

  a_r6_pre_follows_en: assert property (@(posedge clk) disable iff (rst)
    pre_pulse |-> $past(uclk_en));

  a_r8_clear_quiets: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!uclk_en && !pre_pulse));
endmodule

bind frac_baud_gen frac_baud_gen_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr_w), .modv(mod_w), .acc(acc_w),
  .uclk_en(uclk_en), .pre_pulse(pre_pulse_w), .baud_tick(baud_tick)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int A_DIVL = 8'h00, A_DIVH = 8'h04, A_PRE = 8'h30, A_MUL = 8'h34, A_MOD = 8'h38;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic uclk_en, baud_tick;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  frac_baud_gen u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .uclk_en(uclk_en), .baud_tick(baud_tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    addr = AW'(a); wdata = DW'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr = AW'(a);
    @(negedge clk);
    d = int'(rdata);
  endtask

  task automatic setup(input int m, input int md, input int p, input int dv);
    wr(A_MOD, 0);
    wr(A_MUL, m);
    wr(A_PRE, p);
    wr(A_DIVL, dv & 8'hff);
    wr(A_DIVH, dv >> 8);
    wr(A_MOD, md);
  endtask

  // cycles from now until baud_tick seen, -1 if none within lim
  task automatic wait_tick(input int lim, output int k);
    k = -1;
    for (int i = 1; i <= lim; i++) begin
      @(negedge clk);
      if (baud_tick) begin k = i; break; end
    end
  endtask

  task automatic t_reset;
    int d;
    rd(A_MUL, d);  check(d == 96,  "R1 mul reset", d, 96);
    rd(A_MOD, d);  check(d == 125, "R1 mod reset", d, 125);
    rd(A_PRE, d);  check(d == 16,  "R1 pre reset", d, 16);
    rd(A_DIVL, d); check(d == 16,  "R1 divl reset", d, 16);
    rd(A_DIVH, d); check(d == 0,   "R1 divh reset", d, 0);
  endtask

  task automatic t_default_ratio;
    int ticks = 0;
    for (int i = 0; i < 100000; i++) begin
      @(negedge clk);
      if (baud_tick) ticks++;
    end
    check(ticks >= 299 && ticks <= 301, "R9 default tick count", ticks, 300);
  endtask

  task automatic t_enable_rate;
    int ens = 0;
    setup(3, 7, 1, 1);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 70; i++) begin
      @(negedge clk);
      if (uclk_en) ens++;
    end
    check(ens == 30, "R3 enable rate 3/7", ens, 30);
  endtask

  task automatic t_period;
    int k;
    setup(1, 4, 2, 3);
    wait_tick(200, k);
    wait_tick(200, k);
    check(k == 24, "R6 tick period", k, 24);
    @(negedge clk);
    check(baud_tick == 1'b0, "R10 single cycle tick", baud_tick, 0);
  endtask

  task automatic t_zero_limits;
    int k;
    setup(1, 2, 0, 0);
    wait_tick(50, k);
    wait_tick(50, k);
    check(k == 2, "R7 zero prescale and divisor", k, 2);
  endtask

  task automatic t_mod_zero;
    int act = 0;
    wr(A_MOD, 0);
    repeat (3) @(negedge clk);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (uclk_en || baud_tick) act++;
    end
    check(act == 0, "R4 modulus zero idle", act, 0);
  endtask

  task automatic t_mul_over;
    int hi = 0;
    setup(9, 3, 1, 1);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (uclk_en && baud_tick) hi++;
    end
    check(hi == 20, "R5 multiplier above modulus", hi, 20);
  endtask

  task automatic t_clear_phase(input int ph);
    int k;
    setup(1, 4, 2, 1);
    repeat (ph) @(negedge clk);
    wr(A_PRE, 2);
    @(negedge clk);
    wait_tick(40, k);
    if (k > 0) k = k + 1;
    check(k == 10, $sformatf("R8 clear at phase %0d", ph), k, 10);
  endtask

  task automatic t_map;
    int d;
    wr(A_MUL, 32'h1234);  rd(A_MUL, d);  check(d == 32'h1234, "R2 mul readback", d, 32'h1234);
    wr(A_MOD, 32'hBEEF);  rd(A_MOD, d);  check(d == 32'hBEEF, "R2 mod readback", d, 32'hBEEF);
    wr(A_PRE, 32'hA5);    rd(A_PRE, d);  check(d == 32'hA5, "R2 pre readback", d, 32'hA5);
    wr(A_DIVL, 32'h15A);  rd(A_DIVL, d); check(d == 32'h5A, "R2 divl readback", d, 32'h5A);
    wr(A_DIVH, 32'hC3);   rd(A_DIVH, d); check(d == 32'hC3, "R2 divh readback", d, 32'hC3);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_default_ratio();
    t_enable_rate();
    t_period();
    t_zero_limits();
    t_mod_zero();
    t_mul_over();
    for (int ph = 0; ph < 6; ph++) t_clear_phase(ph);
    t_map();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule